// File: doc/BRIEF.md
# Interrupt Priority Resolver with Accepted-Group Latch

This block sits between the per-group interrupt storage of an interrupt controller and the processor. It looks at the request, enable and priority level of every maskable group on every cycle. It picks the pending group with the best priority and presents that group's level to the processor as a 3-bit code. Level 7 means that nothing is pending.

The lower groups are non-maskable and never take part in the level selection. An input event on one of them produces a one-cycle pulse on a separate output, but only while that group has an enabled request.

When the processor takes an interrupt, it strobes an acknowledge and returns the level it accepted. The block then latches the winning group number into an accepted-group register, which software can read through a byte port. The register reads as zero once the latched group's enabled request has gone away. If the returned level differs from the level being presented, a sticky error flag is raised.

Top module: `icp_level_resolver`

## Requirements
- R1: Only groups FIRST_MASK..NUM_GROUPS-1 (2..30 by default) are candidates, and only while the AND of their request and enable bits is nonzero. Requests on the non-maskable groups 0 and 1, or requests whose enable bits are clear, leave the level at 7.
- R2: With no candidate, the selection is group 0 and the level output is 7.
- R3: A candidate beats the current choice only when its level is strictly lower. Scanning goes upward from the lowest group number, so on equal levels the lowest group number wins. Level 0 is the best priority.
- R4: The level output is registered. It shows the selection made from the inputs present at the previous rising clock edge.
- R5: When ack_stb is high at a clock edge, the group number behind the currently presented level is stored in the accepted-group register.
- R6: When ack_stb is high and ack_lvl differs from the presented level, ack_err_o rises at the next edge and stays high until reset. An acknowledge with a matching level leaves it unchanged.
- R7: With rd_off = 0, rd_data_o returns the accepted group number shifted left by 2 (bits 6:2) while that group's request AND enable is nonzero, and 0 otherwise. The read is combinational from the current inputs.
- R8: With rd_off = 1, rd_data_o reads 0.
- R9: nmi_o is high for one cycle after an edge at which nmi_evt[g] was high and group g (g = 0 or 1) had a nonzero request AND enable. Otherwise it stays low.
- R10: After reset, level_o is 7, nmi_o and ack_err_o are 0, and the accepted group is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grp_req | input | NUM_GROUPS*SRC_W | Request bits, SRC_W per group, group g at [g*SRC_W +: SRC_W] |
| grp_en | input | NUM_GROUPS*SRC_W | Enable bits, same layout as grp_req |
| grp_lvl | input | (NUM_GROUPS-FIRST_MASK)*3 | Level of each maskable group, group g at [(g-FIRST_MASK)*3 +: 3] |
| nmi_evt | input | FIRST_MASK | Input event strobe for each non-maskable group |
| ack_stb | input | 1 | Processor acknowledge strobe |
| ack_lvl | input | 3 | Level accepted by the processor |
| rd_off | input | 1 | Byte offset of the accepted-group register being read |
| level_o | output | 3 | Registered winning level, 7 when idle |
| nmi_o | output | 1 | One-cycle non-maskable interrupt pulse |
| ack_err_o | output | 1 | Sticky acknowledge-level mismatch flag |
| rd_data_o | output | 8 | Accepted-group register read data |

## Verification
The bench builds the block with its default parameters: 31 groups of four sources each, with groups 0 and 1 non-maskable. This covers both non-maskable groups, the first maskable group and the top group 30, so the scan can be tested at both ends of its range. It can also be tested with many groups tied on one level. A behavioural model in the bench predicts the level, the pulse, the error flag and the read data every cycle. The inputs are driven with directed cases and then with a long run of random request, enable and level patterns that mix matching and mismatching acknowledges.

// File: rtl/icp_pkg.sv
// Package: shared types and constants for the interrupt priority resolver.
// Assumes a 3-bit level code where the numerically largest value means idle.
package icp_pkg;
    localparam int LVL_W = 3;
    typedef logic [LVL_W-1:0] lvl_t;
    localparam lvl_t IDLE_LEVEL = lvl_t'((1 << LVL_W) - 1);
endpackage

// File: rtl/icp_cand_sel.sv
// Module: combinational scan over the maskable groups that returns the
// group with the strictly lowest level among those with an enabled request.
// Assumes the inputs hold only the maskable groups, the lowest first; the
// reported group number is offset by FIRST_MASK. Group 0 means "none".
module icp_cand_sel
    import icp_pkg::*;
#(
    parameter int NUM_GROUPS = 31,
    parameter int FIRST_MASK = 2,
    parameter int SRC_W      = 4,
    localparam int NUM_MASK  = NUM_GROUPS - FIRST_MASK,
    localparam int GID_W     = $clog2(NUM_GROUPS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_MASK*SRC_W-1:0] req_m,
    input  logic [NUM_MASK*SRC_W-1:0] en_m,
    input  logic [NUM_MASK*LVL_W-1:0] lvl_m,
    output logic [GID_W-1:0]          sel_gid,
    output lvl_t                      sel_lvl
);
    logic [NUM_MASK-1:0] act;
    lvl_t                lvl_arr [NUM_MASK];

    // Unpack each maskable group: active flag and level.
    for (genvar g = 0; g < NUM_MASK; g++) begin : g_unpack
        assign act[g]     = |(req_m[g*SRC_W +: SRC_W] & en_m[g*SRC_W +: SRC_W]);
        assign lvl_arr[g] = lvl_m[g*LVL_W +: LVL_W];
    end

    // Upward scan; only a strictly lower level displaces the current choice.
    always_comb begin
        sel_gid = '0;
        sel_lvl = IDLE_LEVEL;
        for (int g = 0; g < NUM_MASK; g++) begin
            if (act[g] && (lvl_arr[g] < sel_lvl)) begin
                sel_gid = GID_W'(g + FIRST_MASK);
                sel_lvl = lvl_arr[g];
            end
        end
    end

    // A non-idle winner must be a maskable group that is really pending.
    assert_winner_active_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_gid != '0) |-> ((int'(sel_gid) >= FIRST_MASK) && act[int'(sel_gid) - FIRST_MASK]));

    // With no winner the presented level must be the idle code.
    assert_idle_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_gid == '0) |-> (sel_lvl == IDLE_LEVEL));
endmodule

// File: rtl/icp_nmi_gen.sv
// Module: registered one-cycle pulse for the non-maskable groups.
// Assumes nmi_evt is a one-cycle strobe per group, aligned with req/en.
module icp_nmi_gen #(
    parameter int NMI_GROUPS = 2,
    parameter int SRC_W      = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NMI_GROUPS-1:0]       nmi_evt,
    input  logic [NMI_GROUPS*SRC_W-1:0] req_n,
    input  logic [NMI_GROUPS*SRC_W-1:0] en_n,
    output logic                        nmi_o
);
    logic [NMI_GROUPS-1:0] fire;

    // A group fires when its event arrives while its request is enabled.
    for (genvar g = 0; g < NMI_GROUPS; g++) begin : g_fire
        assign fire[g] = nmi_evt[g] & (|(req_n[g*SRC_W +: SRC_W] & en_n[g*SRC_W +: SRC_W]));
    end

    // Register the OR of all firing groups as the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_o <= 1'b0;
        else        nmi_o <= |fire;
    end

    // A pulse must always trace back to an event in the previous cycle.
    assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |-> $past(|nmi_evt));
endmodule

// File: rtl/icp_accept_reg.sv
// Module: accepted-group latch and its byte read port.
// Assumes sel_gid_q is the group behind the level currently presented,
// and that group numbers plus two shift bits fit in RD_W.
module icp_accept_reg #(
    parameter int NUM_GROUPS = 31,
    parameter int SRC_W      = 4,
    parameter int RD_W       = 8,
    localparam int GID_W     = $clog2(NUM_GROUPS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ack_stb,
    input  logic [GID_W-1:0]            sel_gid_q,
    input  logic [NUM_GROUPS*SRC_W-1:0] req,
    input  logic [NUM_GROUPS*SRC_W-1:0] en,
    input  logic                        rd_off,
    output logic [RD_W-1:0]             rd_data
);
    logic [GID_W-1:0] acc_q;
    logic             acc_live;

    // Capture the presented winner on each acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)       acc_q <= '0;
        else if (ack_stb) acc_q <= sel_gid_q;
    end

    // Check whether the latched group still has an enabled request.
    assign acc_live = |(req[acc_q*SRC_W +: SRC_W] & en[acc_q*SRC_W +: SRC_W]);

    // Byte 0 returns the shifted group while live; every other byte is zero.
    always_comb begin
        if (!rd_off && acc_live) rd_data = RD_W'({acc_q, 2'b00});
        else                     rd_data = '0;
    end

    assert_latch_on_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_stb |=> (acc_q == $past(sel_gid_q)));

    assert_high_byte_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_off |-> (rd_data == '0));
endmodule

// File: rtl/icp_level_resolver.sv
// Module: top of the priority resolver. It registers the winning level and
// group, raises a sticky flag on mismatched acknowledges, and wires the
// non-maskable pulse generator and the accepted-group register.
// Assumes groups 0..FIRST_MASK-1 are non-maskable and the rest maskable.
module icp_level_resolver
    import icp_pkg::*;
#(
    parameter int NUM_GROUPS = 31,
    parameter int FIRST_MASK = 2,
    parameter int SRC_W      = 4,
    parameter int RD_W       = 8,
    localparam int NUM_MASK  = NUM_GROUPS - FIRST_MASK,
    localparam int GID_W     = $clog2(NUM_GROUPS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_GROUPS*SRC_W-1:0] grp_req,
    input  logic [NUM_GROUPS*SRC_W-1:0] grp_en,
    input  logic [NUM_MASK*LVL_W-1:0]   grp_lvl,
    input  logic [FIRST_MASK-1:0]       nmi_evt,
    input  logic                        ack_stb,
    input  logic [LVL_W-1:0]            ack_lvl,
    input  logic                        rd_off,
    output logic [LVL_W-1:0]            level_o,
    output logic                        nmi_o,
    output logic                        ack_err_o,
    output logic [RD_W-1:0]             rd_data_o
);
    logic [GID_W-1:0] sel_gid;
    lvl_t             sel_lvl;
    logic [GID_W-1:0] gid_q;
    lvl_t             level_q;
    logic             run_q;

    icp_cand_sel #(
        .NUM_GROUPS(NUM_GROUPS),
        .FIRST_MASK(FIRST_MASK),
        .SRC_W     (SRC_W)
    ) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_m  (grp_req[NUM_GROUPS*SRC_W-1:FIRST_MASK*SRC_W]),
        .en_m   (grp_en[NUM_GROUPS*SRC_W-1:FIRST_MASK*SRC_W]),
        .lvl_m  (grp_lvl),
        .sel_gid(sel_gid),
        .sel_lvl(sel_lvl)
    );

    // Register the winner so that the level leaves the block from a flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gid_q   <= '0;
            level_q <= IDLE_LEVEL;
        end else begin
            gid_q   <= sel_gid;
            level_q <= sel_lvl;
        end
    end

    // Sticky flag for an acknowledge that disagrees with the presented level.
    always_ff @(posedge clk) begin
        if (!rst_n)                            ack_err_o <= 1'b0;
        else if (ack_stb && ack_lvl != level_q) ack_err_o <= 1'b1;
    end

    // Marks cycles where the level register holds a post-reset selection.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
    end

    assign level_o = level_q;

    icp_nmi_gen #(
        .NMI_GROUPS(FIRST_MASK),
        .SRC_W     (SRC_W)
    ) u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .nmi_evt(nmi_evt),
        .req_n  (grp_req[FIRST_MASK*SRC_W-1:0]),
        .en_n   (grp_en[FIRST_MASK*SRC_W-1:0]),
        .nmi_o  (nmi_o)
    );

    icp_accept_reg #(
        .NUM_GROUPS(NUM_GROUPS),
        .SRC_W     (SRC_W),
        .RD_W      (RD_W)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_stb  (ack_stb),
        .sel_gid_q(gid_q),
        .req      (grp_req),
        .en       (grp_en),
        .rd_off   (rd_off),
        .rd_data  (rd_data_o)
    );

    assert_level_lag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (level_o == $past(sel_lvl)));

    assert_err_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb && (ack_lvl != level_o)) |=> ack_err_o);

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err_o |=> ack_err_o);
endmodule

// File: tb/tb_icp_level_resolver.sv
module tb_icp_level_resolver;
    localparam int N  = 31;
    localparam int F  = 2;
    localparam int W  = 4;
    localparam int NM = N - F;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N*W-1:0]   grp_req = '0;
    logic [N*W-1:0]   grp_en = '0;
    logic [NM*3-1:0]  grp_lvl = '0;
    logic [F-1:0]     nmi_evt = '0;
    logic             ack_stb = 1'b0;
    logic [2:0]       ack_lvl = 3'd0;
    logic             rd_off = 1'b0;
    logic [2:0]       level_o;
    logic             nmi_o;
    logic             ack_err_o;
    logic [7:0]       rd_data_o;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    int m_level = 7;
    int m_gid = 0;
    int m_acc = 0;
    bit m_err = 0;
    bit m_nmi = 0;

    always #2 clk = ~clk;

    icp_level_resolver dut (
        .clk(clk), .rst_n(rst_n), .grp_req(grp_req), .grp_en(grp_en),
        .grp_lvl(grp_lvl), .nmi_evt(nmi_evt), .ack_stb(ack_stb),
        .ack_lvl(ack_lvl), .rd_off(rd_off), .level_o(level_o),
        .nmi_o(nmi_o), .ack_err_o(ack_err_o), .rd_data_o(rd_data_o)
    );

    function automatic bit live(int g);
        return ((grp_req[g*W +: W] & grp_en[g*W +: W]) != 0);
    endfunction

    function automatic int lvl_of(int g);
        return int'(grp_lvl[(g-F)*3 +: 3]);
    endfunction

    function automatic int ref_pick();
        int best = 0;
        int bl = 7;
        for (int g = F; g < N; g++)
            if (live(g) && lvl_of(g) < bl) begin best = g; bl = lvl_of(g); end
        return best;
    endfunction

    function automatic int ref_rd();
        if (rd_off) return 0;
        return live(m_acc) ? (m_acc << 2) : 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FIAL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Advance the model at each edge from the inputs held stable there.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_level = 7; m_gid = 0; m_acc = 0; m_err = 0; m_nmi = 0;
        end else begin
            if (ack_stb) begin
                m_acc = m_gid;
                if (int'(ack_lvl) != m_level) m_err = 1;
            end
            m_nmi = (nmi_evt[0] && live(0)) || (nmi_evt[1] && live(1));
            m_gid = ref_pick();
            m_level = (m_gid == 0) ? 7 : lvl_of(m_gid);
        end
    end

    // Compare every output at each falling edge.
    always @(negedge clk) begin
        chk("R4 level", int'(level_o), m_level);
        chk("R9 nmi", int'(nmi_o), int'(m_nmi));
        chk("R6 err", int'(ack_err_o), int'(m_err));
        chk(rd_off ? "R8 rd" : "R7 rd", int'(rd_data_o), ref_rd());
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic set_grp(int g, int rq, int en, int lv);
        grp_req[g*W +: W] = W'(rq);
        grp_en[g*W +: W]  = W'(en);
        if (g >= F) grp_lvl[(g-F)*3 +: 3] = 3'(lv);
    endtask

    task automatic do_ack(int lv);
        ack_stb = 1'b1; ack_lvl = 3'(lv);
        step();
        ack_stb = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) step();
        // R10: reset values
        chk("R10 level", int'(level_o), 7);
        chk("R10 nmi", int'(nmi_o), 0);
        chk("R10 err", int'(ack_err_o), 0);
        rst_n = 1'b1;
        step();

        // R1: NMI-group requests and disabled requests do not select
        set_grp(0, 1, 15, 0); set_grp(1, 2, 15, 0); set_grp(5, 1, 0, 1);
        step(); step();
        chk("R1 level", int'(level_o), 7);
        chk("R2 idle", int'(level_o), 7);

        // R4: one-cycle latency of the level
        set_grp(5, 1, 1, 4);
        chk("R4 before edge", int'(level_o), 7);
        step();
        chk("R4 after edge", int'(level_o), 4);

        // R3: tie keeps the lower group number
        set_grp(9, 8, 8, 4);
        step(); step();
        chk("R3 tie", int'(level_o), 4);
        // R5/R7: ack latches group 5, read returns 20
        do_ack(4);
        chk("R5 acc", int'(rd_data_o), 20);
        chk("R6 match", int'(ack_err_o), 0);
        // R8: upper byte
        rd_off = 1'b1; #1;
        chk("R8 byte1", int'(rd_data_o), 0);
        rd_off = 1'b0;
        // R7: drop request of group 5, read goes to 0
        set_grp(5, 0, 1, 4);
        #1 chk("R7 lost", int'(rd_data_o), 0);
        step();
        chk("R3 next", int'(level_o), 4);
        set_grp(9, 8, 8, 2); step(); step();
        chk("R3 lower", int'(level_o), 2);
        set_grp(30, 4, 4, 0); step(); step();
        chk("R3 top group", int'(level_o), 0);
        do_ack(0);
        chk("R5 acc30", int'(rd_data_o), 120);
        // R6: mismatch, then sticky
        do_ack(3); step();
        chk("R6 set", int'(ack_err_o), 1);
        do_ack(0); step();
        chk("R6 sticky", int'(ack_err_o), 1);

        // R9: NMI pulse only with enabled request
        nmi_evt = 2'b10; step(); nmi_evt = 2'b00;
        chk("R9 pulse", int'(nmi_o), 1);
        step();
        chk("R9 one cycle", int'(nmi_o), 0);
        set_grp(0, 1, 0, 0); set_grp(1, 2, 0, 0);
        nmi_evt = 2'b11; step(); nmi_evt = 2'b00;
        chk("R9 masked", int'(nmi_o), 0);

        // Random phase, checked by the model every cycle
        for (int i = 0; i < 3000; i++) begin
            int g = $urandom_range(N-1);
            set_grp(g, $urandom_range(15), $urandom_range(15) & $urandom_range(15),
                    $urandom_range(7));
            nmi_evt = F'($urandom_range(3));
            rd_off = ($urandom_range(7) == 0);
            if ($urandom_range(5) == 0) begin
                ack_stb = 1'b1;
                ack_lvl = ($urandom_range(15) == 0) ? 3'($urandom_range(7)) : 3'(m_level);
            end else ack_stb = 1'b0;
            if (i == 1500) rst_n = 1'b0;
            if (i == 1502) begin
                chk("R10 mid", int'(ack_err_o), 0);
                rst_n = 1'b1;
            end
            step();
        end
        ack_stb = 1'b0;
        step();
        summary();
        $finish;
    end
endmodule